// File: doc/BRIEF.md
# Memory-card status and interrupt register block

This block is a small register window for a memory-card slot. It answers a 32-bit, word-addressed register bus with two fixed identity and decode constants and with a status word. The status word carries two bits. One is a live copy of the card's write-protect signal. The other is a latched card-inserted event flag.

The card-inserted flag is sticky. It is set whenever the synchronized card-insert input is high, and it holds after that input falls. Software clears it by writing a one to its bit position in the status word. The flag itself is the block's interrupt output, so the interrupt stays asserted until software acknowledges the event.

Both slot inputs are asynchronous. Each is brought into the clock domain through a flop-chain synchronizer before it is used. Reads are registered. The data for a read cycle appears on the read-data port after the next rising edge, and it holds until the next read.

Top module: `card_stat_regs`

## Requirements
- R1: A read of word 0 returns the identity constant 0x41034003.
- R2: A read of word 1 returns zero, and writes to word 1 change nothing that a later read or the interrupt shows.
- R3: A read of word 3 returns 0x11, and writes to word 3 change nothing.
- R4: Word 2 bit 0 shows the synchronized write-protect level, following it both high and low. Writing word 2, including writing bit 0, does not change this bit. All other status bits except bit 3 read zero.
- R5: Word 2 bit 3, the card-inserted flag, sets while the synchronized card-insert input is high and stays set after that input falls.
- R6: A write to word 2 with bit 3 at one clears the card-inserted flag. A write to word 2 with bit 3 at zero leaves the flag unchanged.
- R7: If the synchronized card-insert input is high in the cycle of a clearing write, the flag stays at one.
- R8: The interrupt output equals the card-inserted flag at all times.
- R9: Reads of any word above 3 return zero, and writes there change nothing.
- R10: Each slot input passes two synchronizer flops. A card-insert input raised before rising edge 0 shows on the interrupt after edge 2, and not after edge 1.
- R11: After reset the flag, the interrupt and the read data are all zero.
- R12: Read data is registered. It shows the addressed word after the edge that samples the read strobe, and it holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_in | input | 1 | Asynchronous write-protect level from the slot |
| cd_in | input | 1 | Asynchronous card-insert event level from the slot |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Card-inserted interrupt, equal to the sticky flag |

## Verification
The bench uses the default parameters. ADDR_W is 4, which leaves words 4 to 15 as out-of-range addresses, so reads and writes above the decoded window can be exercised. SYNC_STAGES is 2, which fixes the input-to-interrupt latency at a known edge count; the bench checks that latency exactly, one cycle too early and on time. With a 32-bit data width, the clear mask and the ignored bits can be driven across a full word, including all-ones writes to the constant and out-of-range words.

// File: rtl/card_stat_pkg.sv
package card_stat_pkg;
  localparam int unsigned IDX_IDENT  = 0;
  localparam int unsigned IDX_FLASH  = 1;
  localparam int unsigned IDX_STATUS = 2;
  localparam int unsigned IDX_DECODE = 3;
  localparam int unsigned IDX_COUNT  = 4;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];

  // Cycles since reset, saturating, so the latency check only looks at
  // history taken after reset.
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  if (STAGES == 2) begin : g_chk2
    // R10: the output is the input as sampled two edges earlier
    a_r10_two_stage: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd2) |-> (sync_o == $past(async_i, 2)));
  end
endmodule

// File: rtl/cs_event_flag.sv
module cs_event_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R5: once set, only a clear removes the flag
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  // R6: a clear without a set drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R7: a set wins over a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
endmodule

// File: rtl/cs_read_port.sv
module cs_read_port
  import card_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(IDX_IDENT);
  localparam logic [ADDR_W-1:0] A_FLASH  = ADDR_W'(IDX_FLASH);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
  localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(IDX_DECODE);

  logic [DATA_W-1:0] word_sel;

  always_comb begin
    case (addr_i)
      A_IDENT:  word_sel = ID_VALUE;
      A_FLASH:  word_sel = '0;
      A_STATUS: word_sel = status_i;
      A_DECODE: word_sel = DECODE_VALUE;
      default:  word_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= word_sel;
  end

  a_r1_ident: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == A_IDENT) |=> (rdata_o == ID_VALUE));
  a_r2_flash_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == A_FLASH) |=> (rdata_o == '0));
  a_r3_decode: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == A_DECODE) |=> (rdata_o == DECODE_VALUE));
  a_r9_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i >= ADDR_W'(IDX_COUNT)) |=> (rdata_o == '0));
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/card_stat_regs.sv
module card_stat_regs
  import card_stat_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WP_BIT      = 0,
  parameter int unsigned CD_BIT      = 3,
  parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
  parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_in,
  input  logic              cd_in,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(IDX_STATUS);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(1) << CD_BIT;

  logic [1:0]        slot_sync;
  logic              wp_s;
  logic              cd_s;
  logic              card_flag;
  logic              clr_hit;
  logic [DATA_W-1:0] clr_bits;
  logic [DATA_W-1:0] status_word;

  cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cd_in, wp_in}),
    .sync_o  (slot_sync)
  );

  assign wp_s = slot_sync[0];
  assign cd_s = slot_sync[1];

  assign clr_bits = bus_wdata & CLR_MASK;
  assign clr_hit  = bus_wr && (bus_addr == A_STATUS) && (|clr_bits);

  cs_event_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (cd_s),
    .clr_i  (clr_hit),
    .flag_o (card_flag)
  );

  always_comb begin
    status_word         = '0;
    status_word[WP_BIT] = wp_s;
    status_word[CD_BIT] = card_flag;
  end

  cs_read_port #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .ID_VALUE     (ID_VALUE),
    .DECODE_VALUE (DECODE_VALUE)
  ) u_read (
    .clk      (clk),
    .rst      (rst),
    .rd_i     (bus_rd),
    .addr_i   (bus_addr),
    .status_i (status_word),
    .rdata_o  (bus_rdata)
  );

  assign irq_o = card_flag;

  // R8: the status flag read back matches the interrupt seen in the read cycle
  a_r8_irq_matches_status: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STATUS) |=> (bus_rdata[CD_BIT] == $past(irq_o)));
  // R11: reset leaves the interrupt low
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_o && bus_rdata == '0));
endmodule

// File: tb/test_card_stat_regs.sv
`timescale 1ns/1ps
module test_card_stat_regs;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_in = 1'b0;
  logic          cd_in = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  card_stat_regs i_card_stat_regs (
    .clk(clk), .rst(rst), .wp_in(wp_in), .cd_in(cd_in),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and queue what it must return
  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_rd   = 1'b1;
    bus_addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] stat(input logic flag, input logic wp);
    return (DW'(flag) << 3) | DW'(wp);
  endfunction

  // Monitor: compare read data one edge after a sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check("R11 rdata after reset", bus_rdata, '0);
    check("R11 irq after reset", DW'(irq_o), '0);

    rd(0, 32'h4103_4003, "R1 identity word");
    rd(1, 32'h0, "R2 flash word reads zero");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h0, "R2 flash word after write");
    rd(3, 32'h11, "R3 decode word");
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h11, "R3 decode word after write");
    rd(2, stat(0, 0), "R2 status unaffected by word1/3 writes");

    // R12: read data holds between reads
    idle(3);
    check("R12 hold", bus_rdata, stat(0, 0));

    // R4: live write-protect mirror
    wp_in = 1'b1;
    idle(4);
    rd(2, stat(0, 1), "R4 wp high");
    wr(2, 32'hFFFF_FFF7);
    rd(2, stat(0, 1), "R4 write without bit3 keeps wp and flag");
    wp_in = 1'b0;
    idle(4);
    wr(2, 32'h0000_0001);
    rd(2, stat(0, 0), "R4 wp low, bit0 write ignored");

    // R10: exact synchronizer latency for the card-insert path
    @(negedge clk);
    cd_in = 1'b1;
    @(negedge clk);
    check("R10 irq after edge0", DW'(irq_o), 0);
    @(negedge clk);
    check("R10 irq after edge1", DW'(irq_o), 0);
    @(negedge clk);
    check("R10 irq after edge2", DW'(irq_o), 1);

    // R7: clear while input still high keeps the flag
    wr(2, 32'h0000_0008);
    rd(2, stat(1, 0), "R7 set wins over clear");
    check("R7 irq still high", DW'(irq_o), 1);

    // R5: sticky after the input falls
    cd_in = 1'b0;
    idle(5);
    rd(2, stat(1, 0), "R5 flag sticky");
    check("R8 irq equals flag while set", DW'(irq_o), 1);

    // R6: writing zero at bit3 does not clear
    wr(2, 32'h0000_0000);
    rd(2, stat(1, 0), "R6 zero write keeps flag");

    // R9: out-of-range words
    rd(4, 32'h0, "R9 word4 reads zero");
    rd(15, 32'h0, "R9 word15 reads zero");
    wr(10, 32'hFFFF_FFFF);
    rd(2, stat(1, 0), "R9 out-of-range write ignored");

    // R6: clear by writing one
    wr(2, 32'h0000_0008);
    idle(1);
    check("R8 irq low after clear", DW'(irq_o), 0);
    rd(2, stat(0, 0), "R6 flag cleared");

    // R5 with both inputs high, then clear once input drops
    wp_in = 1'b1;
    cd_in = 1'b1;
    idle(4);
    cd_in = 1'b0;
    idle(4);
    rd(2, stat(1, 1), "R5 flag and wp together");
    wr(2, 32'hFFFF_FFFF);
    rd(2, stat(0, 1), "R6 all-ones clear keeps wp");

    idle(3);
    check("R12 queue drained", DW'(exp_q.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule